// File: doc/BRIEF.md
# Trimmed-Mean Measurement Filter

This block reduces a stream of 12-bit converter codes into one filtered code per measurement, separately for each of several sensor channels. Every incoming sample carries a channel tag. Each channel has its own 3-bit mode. The mode sets how many samples make up one measurement, and whether the single largest and single smallest are thrown away before averaging.

Averaging modes always leave a power-of-two number of samples after trimming. The division is therefore a right shift of a running sum. Each channel keeps only a running sum, a running minimum and a running maximum. No sample history is stored.

A result appears one clock after the sample that completes its measurement. It carries the tag of the channel it belongs to. A channel's mode is fixed when its measurement starts. If the mode is changed part-way through, the partial accumulation is abandoned and the next sample starts a new measurement under the new mode.

Top module: `thf_top`

## Requirements
- R1: In mode 0 each sample is returned unchanged as a result, with its channel tag, on the clock after it is accepted.
- R2: In mode 1 a measurement is 2 samples; the result is their sum shifted right by 1 (truncated).
- R3: In mode 2 a measurement is 4 samples; one maximum and one minimum are removed and the remaining 2 are averaged by a right shift of 1.
- R4: In mode 3 a measurement is 6 samples; one maximum and one minimum are removed and the remaining 4 are averaged by a right shift of 2.
- R5: In mode 4 a measurement is 10 samples (remaining 8, shift 3); in mode 5 it is 18 samples (remaining 16, shift 4); in both, one maximum and one minimum are removed.
- R6: When several samples share the largest or smallest value, exactly one copy of each is removed.
- R7: Mode codes 6 and 7 behave exactly as mode 0.
- R8: Channel n takes its mode from bits 3n+2 down to 3n of `mode_cfg`. Channels accumulate independently, so samples of different channels may be interleaved freely.
- R9: A change of a channel's mode while a measurement is partly collected discards the collected samples; the next sample for that channel starts a new measurement under the new mode.
- R10: `res_valid` is low in reset, and is high only on the clock after a sample that completes a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_sensor | input | 2 | Channel tag of the sample |
| smp_code | input | 12 | Converter code of the sample |
| mode_cfg | input | 12 | Per-channel 3-bit mode fields, channel n at bits 3n+2:3n |
| res_valid | output | 1 | A filtered result is presented this cycle |
| res_sensor | output | 2 | Channel tag of the result |
| res_code | output | 12 | Filtered code |

## Verification
The bench builds the block with its default parameters: four channels and 12-bit codes. This gives the full mode field layout, all six sample counts up to 18 samples, and both extreme codes 0 and 4095. With these sizes, worst-case sums near the 17-bit sum width are reachable in mode 5 with all-4095 inputs. Interleaving all four channels, each in a different mode, exercises channel independence and the shared result path.

// File: rtl/thf_pkg.sv
package thf_pkg;
  localparam int MODE_W = 3;
  localparam int CNT_W  = 5;
  localparam int GROW_W = 5;

  typedef logic [MODE_W-1:0] mode_t;

  // Unused codes fall back to the pass-through mode.
  function automatic mode_t mode_clean(input mode_t m);
    return (m > 3'd5) ? 3'd0 : m;
  endfunction

  function automatic logic [CNT_W-1:0] mode_count(input mode_t m);
    case (m)
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd6;
      3'd4:    return 5'd10;
      3'd5:    return 5'd18;
      default: return 5'd1;
    endcase
  endfunction

  function automatic logic [2:0] mode_shift(input mode_t m);
    case (m)
      3'd1, 3'd2: return 3'd1;
      3'd3:       return 3'd2;
      3'd4:       return 3'd3;
      3'd5:       return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

  function automatic logic mode_trims(input mode_t m);
    return (m >= 3'd2) && (m <= 3'd5);
  endfunction
endpackage

// File: rtl/thf_rst_sync.sv
module thf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/thf_lane.sv
module thf_lane
  import thf_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             cfg_mode,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_code,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int SUM_W = DATA_W + GROW_W;

  logic [CNT_W-1:0]  cnt_q,  cnt_n;
  logic [SUM_W-1:0]  sum_q,  sum_n;
  logic [DATA_W-1:0] min_q,  min_n;
  logic [DATA_W-1:0] max_q,  max_n;
  mode_t             mode_q, mode_n;
  logic              en;

  logic              fresh;
  logic [CNT_W-1:0]  acc_cnt;
  logic [SUM_W-1:0]  acc_sum, trimmed;
  logic [DATA_W-1:0] acc_min, acc_max;

  always_comb begin
    mode_n  = mode_clean(cfg_mode);
    // Start over when idle or when the mode moved under a partial measurement.
    fresh   = (cnt_q == '0) || (mode_n != mode_q);
    acc_cnt = (fresh ? '0 : cnt_q) + 1'b1;
    acc_sum = (fresh ? '0 : sum_q) + SUM_W'(smp_code);
    acc_min = fresh ? smp_code : ((smp_code < min_q) ? smp_code : min_q);
    acc_max = fresh ? smp_code : ((smp_code > max_q) ? smp_code : max_q);
    done    = smp_valid && (acc_cnt == mode_count(mode_n));
    trimmed = mode_trims(mode_n) ? (acc_sum - SUM_W'(acc_min) - SUM_W'(acc_max))
                                 : acc_sum;
    result  = DATA_W'(trimmed >> mode_shift(mode_n));

    en    = smp_valid || (cnt_q != '0 && mode_n != mode_q);
    cnt_n = '0;
    sum_n = acc_sum;
    min_n = acc_min;
    max_n = acc_max;
    if (smp_valid && !done) cnt_n = acc_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sum_q  <= '0;
      min_q  <= '0;
      max_q  <= '0;
      mode_q <= '0;
    end else if (en) begin
      cnt_q  <= cnt_n;
      sum_q  <= sum_n;
      min_q  <= min_n;
      max_q  <= max_n;
      mode_q <= mode_n;
    end
  end
endmodule

// File: rtl/thf_top.sv
module thf_top
  import thf_pkg::*;
#(
  parameter int NUM_SENSORS = 4,
  parameter int DATA_W      = 12,
  localparam int SEL_W      = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1,
  localparam int CFG_W      = NUM_SENSORS * MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SEL_W-1:0]  smp_sensor,
  input  logic [DATA_W-1:0] smp_code,
  input  logic [CFG_W-1:0]  mode_cfg,
  output logic              res_valid,
  output logic [SEL_W-1:0]  res_sensor,
  output logic [DATA_W-1:0] res_code
);
  logic                   rst_sync_n;
  logic [NUM_SENSORS-1:0] lane_done;
  logic [DATA_W-1:0]      lane_res [NUM_SENSORS];
  logic [DATA_W-1:0]      pick;
  logic                   any_done;
  logic                   vld_q;
  logic [SEL_W-1:0]       tag_q;
  logic [DATA_W-1:0]      code_q;

  thf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < NUM_SENSORS; i++) begin : g_lane
    thf_lane #(.DATA_W(DATA_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .cfg_mode  (mode_cfg[i*MODE_W +: MODE_W]),
      .smp_valid (smp_valid && (smp_sensor == SEL_W'(i))),
      .smp_code  (smp_code),
      .done      (lane_done[i]),
      .result    (lane_res[i])
    );
  end

  // At most one lane finishes per cycle, so an OR of masked results selects it.
  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_SENSORS; i++)
      if (lane_done[i]) pick = pick | lane_res[i];
    any_done = |lane_done;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= any_done;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tag_q  <= '0;
      code_q <= '0;
    end else if (any_done) begin
      tag_q  <= smp_sensor;
      code_q <= pick;
    end
  end

  assign res_valid  = vld_q;
  assign res_sensor = tag_q;
  assign res_code   = code_q;
endmodule

// File: rtl/thf_checker.sv
module thf_checker
  import thf_pkg::*;
#(
  parameter int NUM_SENSORS = 4,
  parameter int DATA_W      = 12,
  parameter int SEL_W       = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          smp_valid,
  input logic [SEL_W-1:0]              smp_sensor,
  input logic [DATA_W-1:0]             smp_code,
  input logic [NUM_SENSORS*MODE_W-1:0] mode_cfg,
  input logic                          res_valid,
  input logic [SEL_W-1:0]              res_sensor,
  input logic [DATA_W-1:0]             res_code
);
  logic [NUM_SENSORS-1:0][CNT_W-1:0]  seen_q;
  logic [NUM_SENSORS-1:0][MODE_W-1:0] prev_mode_q;

  // Independent sample tally per channel since its last result or mode change.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= '0;
      prev_mode_q <= '0;
    end else begin
      for (int s = 0; s < NUM_SENSORS; s++) begin
        logic [CNT_W-1:0] base;
        logic             hit;
        mode_t            now;
        now  = mode_clean(mode_cfg[s*MODE_W +: MODE_W]);
        hit  = smp_valid && (smp_sensor == SEL_W'(s));
        base = (res_valid && res_sensor == SEL_W'(s)) ? '0 : seen_q[s];
        if (now != prev_mode_q[s]) base = '0;
        seen_q[s]      <= base + CNT_W'(hit);
        prev_mode_q[s] <= now;
      end
    end
  end

  // R10: a result only follows an accepted sample
  assert_result_needs_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(smp_valid));

  // R8: the result carries the tag of the completing sample
  assert_tag_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_sensor == $past(smp_sensor));

  // R1 (and R7 via the clean mode): pass-through one cycle later
  assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_clean(mode_cfg[smp_sensor*MODE_W +: MODE_W]) == 3'd0)
      |=> (res_valid && res_code == $past(smp_code)));

  // R5: a result appears exactly when the mode's sample count is reached
  assert_sample_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> seen_q[res_sensor] == mode_count(prev_mode_q[res_sensor]));
endmodule

bind thf_top thf_checker #(
  .NUM_SENSORS (NUM_SENSORS),
  .DATA_W      (DATA_W),
  .SEL_W       (SEL_W)
) u_thf_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .smp_valid  (smp_valid),
  .smp_sensor (smp_sensor),
  .smp_code   (smp_code),
  .mode_cfg   (mode_cfg),
  .res_valid  (res_valid),
  .res_sensor (res_sensor),
  .res_code   (res_code)
);

// File: tb/thf_top_tb_top.sv
`timescale 1ns/1ps
module thf_top_tb_top;
  localparam int NS = 4;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid;
  logic [1:0]    smp_sensor;
  logic [DW-1:0] smp_code;
  logic [11:0]   mode_cfg;
  logic          res_valid;
  logic [1:0]    res_sensor;
  logic [DW-1:0] res_code;

  int    n_run = 0, n_fail = 0;
  bit    finished = 0;
  int    exp_s[$], exp_c[$];
  string exp_t[$];
  int    sbuf[NS][$];
  int    smode[NS];

  always #2.5 clk = ~clk;

  thf_top dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sensor(smp_sensor),
    .smp_code(smp_code), .mode_cfg(mode_cfg), .res_valid(res_valid),
    .res_sensor(res_sensor), .res_code(res_code)
  );

  function automatic int clean(int m); return (m > 5) ? 0 : m; endfunction
  function automatic int count_of(int m);
    int t[6] = '{1, 2, 4, 6, 10, 18}; return t[m];
  endfunction
  function automatic int shift_of(int m);
    int t[6] = '{0, 1, 1, 2, 3, 4}; return t[m];
  endfunction

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_mode(int s, int m);
    @(negedge clk);
    smp_valid = 1'b0;
    mode_cfg[s*3 +: 3] = 3'(m);
    if (clean(m) != smode[s]) sbuf[s].delete();
    smode[s] = clean(m);
  endtask

  task automatic send(int s, int code, string tag);
    @(negedge clk);
    smp_valid = 1'b1; smp_sensor = 2'(s); smp_code = DW'(code);
    sbuf[s].push_back(code);
    if (sbuf[s].size() == count_of(smode[s])) begin
      int sum = 0, mn = 1 << DW, mx = -1;
      foreach (sbuf[s][k]) begin
        sum += sbuf[s][k];
        if (sbuf[s][k] < mn) mn = sbuf[s][k];
        if (sbuf[s][k] > mx) mx = sbuf[s][k];
      end
      if (smode[s] >= 2) sum = sum - mn - mx;
      exp_s.push_back(s); exp_c.push_back(sum >> shift_of(smode[s])); exp_t.push_back(tag);
      sbuf[s].delete();
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); smp_valid = 1'b0;
    end
  endtask

  // Monitor: pops expected results as the design produces them.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_s.size() == 0) check("R10 unexpected result", 1, 0);
      else begin
        string t; int es, ec;
        t = exp_t.pop_front(); es = exp_s.pop_front(); ec = exp_c.pop_front();
        check({t, " tag"}, res_sensor, es);
        check({t, " code"}, res_code, ec);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_sensor = '0; smp_code = '0; mode_cfg = '0;
    for (int s = 0; s < NS; s++) smode[s] = 0;
    repeat (3) @(negedge clk);
    check("R10 reset res_valid", res_valid, 0);
    rst_n = 1'b1;
    idle(4);

    // R1: pass-through on sensor 0
    send(0, 0, "R1"); send(0, 4095, "R1"); send(0, 1234, "R1"); idle(2);

    // R2: pairs, truncation and full-scale
    set_mode(0, 1);
    send(0, 3, "R2"); send(0, 4, "R2"); send(0, 4095, "R2"); send(0, 4095, "R2"); idle(2);

    // R3: four samples, trim extremes
    set_mode(0, 2);
    send(0, 10, "R3"); send(0, 50, "R3"); send(0, 20, "R3"); send(0, 30, "R3"); idle(2);

    // R4: six samples
    set_mode(0, 3);
    send(0, 100, "R4"); send(0, 7, "R4"); send(0, 300, "R4");
    send(0, 250, "R4"); send(0, 4000, "R4"); send(0, 123, "R4"); idle(2);

    // R6: ties at both ends
    send(0, 7, "R6"); send(0, 7, "R6"); send(0, 7, "R6");
    send(0, 9, "R6"); send(0, 9, "R6"); send(0, 1, "R6");
    for (int k = 0; k < 6; k++) send(0, 100, "R6");
    idle(2);

    // R5: ten and eighteen samples, random and full-scale
    set_mode(1, 4); set_mode(2, 5);
    for (int r = 0; r < 2; r++) for (int k = 0; k < 10; k++) send(1, $urandom_range(0, 4095), "R5");
    for (int r = 0; r < 2; r++) for (int k = 0; k < 18; k++) send(2, $urandom_range(0, 4095), "R5");
    for (int k = 0; k < 18; k++) send(2, 4095, "R5");
    idle(2);

    // R7: unused codes pass through
    set_mode(1, 6); send(1, 77, "R7"); send(1, 4094, "R7");
    set_mode(1, 7); send(1, 5, "R7"); idle(2);

    // R8: interleaved channels in different modes
    set_mode(0, 3); set_mode(1, 0); set_mode(2, 2); set_mode(3, 1);
    for (int k = 0; k < 24; k++) send(k % 4, $urandom_range(0, 4095), "R8");
    idle(2);

    // R9: mode change mid-measurement discards partial samples
    set_mode(3, 3);
    send(3, 4000, "R9"); send(3, 4000, "R9"); send(3, 4000, "R9");
    set_mode(3, 1);
    send(3, 10, "R9"); send(3, 21, "R9"); idle(2);

    // Random mixed traffic with gaps
    for (int k = 0; k < 200; k++) begin
      send($urandom_range(0, 3), $urandom_range(0, 4095), "R8 mixed");
      if (k % 7 == 0) idle(1);
    end
    idle(4);

    check("R10 all results delivered", exp_s.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule